// File: doc/BRIEF.md
# Serial Interrupt Line Peripheral Encoder

This block reports a vector of level-sensitive interrupt requests over a single shared interrupt wire. The wire is open-drain and is clocked by the PCI clock. Each cycle on the wire starts with a start pulse, which is a run of low clocks. A fixed series of three-clock slots follows, and a short stop pulse ends the cycle. The encoder watches the wire through `lineIn` and finds the start pulse. From the clock that ends it, the encoder counts slots. In the slot assigned to each request it pulls the wire low, pushes it high for one clock, or leaves it alone. The block never drives the pad directly. It produces an enable and a value, and an external open-drain or tri-state pad applies them.

Start ownership follows the length of the stop pulse that closed the last cycle. In Continuous mode, which is the state after reset, only the host may begin a cycle. In Quiet mode the encoder can ask for a cycle itself. When its request vector has changed since the last report and the wire is idle, it pulls the wire low for one clock. The host then extends that pulse into a full start pulse. The request vector is captured once per cycle, so every slot of a cycle reports the same snapshot.

Top module: `serirq_periph`

## Requirements
- R1: The block drives the wire in only three ways: driven low, driven high, or released. Sample, recovery and self-start drives never overlap.
- R2: A start is accepted only while idle. It needs at least 4 consecutive low clocks followed by a high clock, and that high clock is called E. A low run of 1 to 3 clocks followed by high is ignored.
- R3: Slot n (0 to NUM_SLOTS-1) has its sample clock at E+2+3n, its recovery clock at E+3+3n and its turnaround clock at E+4+3n.
- R4: In the sample clock of slot n the block drives low (enable 1, value 0) when bit n of the captured vector is 1. When that bit is 0 it leaves the wire released. Requests are active high.
- R5: In the recovery clock of a slot where it drove low, the block drives high (enable 1, value 1). In every turnaround clock it releases the wire.
- R6: The request vector is captured at the clock edge that ends clock E. Changes made afterwards are not reported until the next cycle.
- R7: After the last slot, the block counts the low clocks before the wire goes high again. A count of exactly 2 selects Quiet mode. Any other nonzero count selects Continuous mode.
- R8: Reset puts the block in Continuous mode with all outputs released. In Continuous mode it never drives the wire while idle, whatever the requests do.
- R9: In Quiet mode, suppose the block sees the wire high while idle and the request vector differs from the last captured one. It then drives the wire low for exactly the next clock and releases it after that.
- R10: Outside the slot clocks and the one self-start clock, the drive enable stays 0, including during start and stop pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | NUM_SLOTS | Interrupt request levels; bit n is reported in slot n |
| lineIn | input | 1 | Value seen on the shared wire |
| driveEn | output | 1 | Pad output enable; 0 releases the wire |
| driveVal | output | 1 | Value to drive when driveEn is 1 |

## Verification
The bench models the host and a pulled-up wire, then predicts the enable and value for every clock. A 3-clock low run must be rejected as a start. A design that accepts it would report slots early. The first and last slot bits are set, so an off-by-one slot count would drive in the wrong clocks. Requests change just after the capture edge. A design that does not hold its snapshot would report the new value in the middle of a cycle. Stop lengths of 2 and 3 switch the mode back and forth, and requests are changed while idle in each mode. A wrong mode choice would produce a self-start pulse where none belongs, or leave one out.

// File: rtl/serirq_pkg.sv
package serirq_pkg;

  // Phase of the current clock, held in a register by the control unit
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_KICK,
    PH_START_TA,
    PH_SAMPLE,
    PH_RECOV,
    PH_TURN,
    PH_STOP
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic latch;   // capture request vector at this edge
    logic kick;    // self-start low drive this clock
    logic sample;  // sample clock of current slot
    logic recov;   // recovery clock of current slot
  } ctl_s;

endpackage

// File: rtl/serirq_ctl.sv
module serirq_ctl
  import serirq_pkg::*;
#(
  parameter int NUM_SLOTS  = 20,
  parameter int START_MIN  = 4,
  parameter int QUIET_STOP = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         lineIn,
  input  logic                         reqPend,
  output ctl_s                         ctl,
  output logic [$clog2(NUM_SLOTS)-1:0] slotIdx,
  output logic                         quietMode
);

  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int CNT_W  = $clog2(START_MIN + QUIET_STOP + 2) + 1;
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;
  localparam logic [CNT_W-1:0]  START_THR = CNT_W'(START_MIN);
  localparam logic [CNT_W-1:0]  QUIET_LEN = CNT_W'(QUIET_STOP);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  phase_e             phase;
  logic [CNT_W-1:0]   lowCnt;
  logic [CNT_W-1:0]   stopCnt;
  logic [SLOT_W-1:0]  slotCnt;
  logic               idleLike;
  logic               startSeen;

  assign idleLike  = (phase == PH_IDLE) || (phase == PH_KICK);
  assign startSeen = idleLike && lineIn && (lowCnt >= START_THR);

  always_comb begin
    ctl.latch  = startSeen;
    ctl.kick   = (phase == PH_KICK);
    ctl.sample = (phase == PH_SAMPLE);
    ctl.recov  = (phase == PH_RECOV);
  end

  assign slotIdx = slotCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      lowCnt    <= '0;
      stopCnt   <= '0;
      slotCnt   <= '0;
      quietMode <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE, PH_KICK: begin
          if (!lineIn) begin
            lowCnt <= (lowCnt == CNT_MAX) ? lowCnt : lowCnt + 1'b1;
            phase  <= PH_IDLE;
          end else if (startSeen) begin
            lowCnt <= '0;
            phase  <= PH_START_TA;
          end else begin
            lowCnt <= '0;
            phase  <= (phase == PH_IDLE && reqPend) ? PH_KICK : PH_IDLE;
          end
        end
        PH_START_TA: begin
          slotCnt <= '0;
          phase   <= PH_SAMPLE;
        end
        PH_SAMPLE: phase <= PH_RECOV;
        PH_RECOV:  phase <= PH_TURN;
        PH_TURN: begin
          if (slotCnt == LAST_SLOT) begin
            stopCnt <= '0;
            phase   <= PH_STOP;
          end else begin
            slotCnt <= slotCnt + 1'b1;
            phase   <= PH_SAMPLE;
          end
        end
        PH_STOP: begin
          if (!lineIn) begin
            stopCnt <= (stopCnt == CNT_MAX) ? stopCnt : stopCnt + 1'b1;
          end else if (stopCnt != '0) begin
            quietMode <= (stopCnt == QUIET_LEN);
            lowCnt    <= '0;
            phase     <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/serirq_dp.sv
module serirq_dp
  import serirq_pkg::*;
#(
  parameter int NUM_SLOTS = 20
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_SLOTS-1:0]         irqIn,
  input  ctl_s                         ctl,
  input  logic [$clog2(NUM_SLOTS)-1:0] slotIdx,
  input  logic                         quietMode,
  output logic                         reqPend,
  output logic                         driveEn,
  output logic                         driveVal
);

  logic [NUM_SLOTS-1:0] irqSnap;
  logic                 slotBit;

  always_ff @(posedge clk) begin
    if (!rstN)          irqSnap <= '0;
    else if (ctl.latch) irqSnap <= irqIn;
  end

  assign slotBit  = irqSnap[slotIdx];
  assign reqPend  = quietMode && (irqIn != irqSnap);
  assign driveEn  = ctl.kick | ((ctl.sample | ctl.recov) & slotBit);
  assign driveVal = ctl.recov & slotBit;

endmodule

// File: rtl/serirq_periph.sv
module serirq_periph
  import serirq_pkg::*;
#(
  parameter int NUM_SLOTS  = 20,
  parameter int START_MIN  = 4,
  parameter int QUIET_STOP = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SLOTS-1:0] irqIn,
  input  logic                 lineIn,
  output logic                 driveEn,
  output logic                 driveVal
);

  localparam int SLOT_W = $clog2(NUM_SLOTS);

  ctl_s              ctl;
  logic [SLOT_W-1:0] slotIdx;
  logic              quietMode;
  logic              reqPend;

  serirq_ctl #(
    .NUM_SLOTS (NUM_SLOTS),
    .START_MIN (START_MIN),
    .QUIET_STOP(QUIET_STOP)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineIn),
    .reqPend  (reqPend),
    .ctl      (ctl),
    .slotIdx  (slotIdx),
    .quietMode(quietMode)
  );

  serirq_dp #(
    .NUM_SLOTS(NUM_SLOTS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .irqIn    (irqIn),
    .ctl      (ctl),
    .slotIdx  (slotIdx),
    .quietMode(quietMode),
    .reqPend  (reqPend),
    .driveEn  (driveEn),
    .driveVal (driveVal)
  );

endmodule

// File: rtl/serirq_chk.sv
module serirq_chk
  import serirq_pkg::*;
#(
  parameter int NUM_SLOTS = 20
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         driveEn,
  input logic                         driveVal,
  input ctl_s                         ctl,
  input logic [$clog2(NUM_SLOTS)-1:0] slotIdx,
  input logic                         quietMode
);

  p_drive_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.kick, ctl.sample, ctl.recov}));

  p_slot_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    int'(slotIdx) <= NUM_SLOTS - 1);

  p_sample_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.sample && driveEn) |-> !driveVal);

  p_high_after_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn && driveVal) |-> $past(driveEn && !driveVal));

  p_release_after_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn && driveVal) |=> !driveEn);

  p_kick_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.kick |-> quietMode);

  p_kick_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.kick |=> !ctl.kick);

  p_no_stray_drive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.kick || ctl.sample || ctl.recov) |-> !driveEn);

endmodule

bind serirq_periph serirq_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .driveEn  (driveEn),
  .driveVal (driveVal),
  .ctl      (ctl),
  .slotIdx  (slotIdx),
  .quietMode(quietMode)
);

// File: tb/serirq_periph_tb.sv
`timescale 1ns/1ps
module serirq_periph_tb;
  localparam int N = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rstN;
  logic [N-1:0] irqIn;
  logic         hostEn, hostVal;
  logic         driveEn, driveVal;
  logic         lineBus;

  // pulled-up shared wire
  assign lineBus = hostEn ? hostVal : (driveEn ? driveVal : 1'b1);

  typedef struct {
    logic  en;
    logic  val;
    string tag;
  } exp_t;
  exp_t expQ[$];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  serirq_periph #(.NUM_SLOTS(N)) u_dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .lineIn(lineBus),
    .driveEn(driveEn), .driveVal(driveVal)
  );

  // driver: sets host side of one clock and queues the expected outputs
  task automatic step(input logic hE, input logic hV, input logic eE,
                      input logic eV, input string tag);
    @(posedge clk);
    #1;
    hostEn  = hE;
    hostVal = hV;
    expQ.push_back('{eE, eV, tag});
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b0, 1'b0, tag);
  endtask

  // one full cycle on the wire, as the host runs it
  task automatic runCycle(input bit kicked, input int lowLen,
                          input logic [N-1:0] rep, input logic [N-1:0] midIrq,
                          input int stopLen);
    if (kicked) step(1'b0, 1'b1, 1'b1, 1'b0, "R9 self-start low");
    for (int i = 0; i < lowLen; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R2 start low");
    step(1'b1, 1'b1, 1'b0, 1'b0, "R2 start end");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R3 start turnaround");
    irqIn = midIrq;  // R6: after capture edge
    for (int s = 0; s < N; s++) begin
      step(1'b0, 1'b1, rep[s], 1'b0, "R3 R4 R6 sample");
      step(1'b0, 1'b1, rep[s], 1'b1, "R3 R5 recovery");
      step(1'b0, 1'b1, 1'b0,   1'b0, "R5 turnaround");
    end
    for (int i = 0; i < stopLen; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R7 R10 stop low");
    step(1'b1, 1'b1, 1'b0, 1'b0, "R7 stop end");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R10 idle after stop");
  endtask

  // monitor: compares the outputs in the middle of each clock
  initial begin
    forever begin
      exp_t e;
      @(negedge clk);
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        checks++;
        if (driveEn !== e.en || (e.en && driveVal !== e.val)) begin
          fails++;
          $display("FAIL %s: en=%b val=%b expected en=%b val=%b",
                   e.tag, driveEn, driveVal, e.en, e.val);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  localparam logic [N-1:0] PAT_A = 20'h80001;  // first and last slot
  localparam logic [N-1:0] PAT_B = 20'h05A5A;
  localparam logic [N-1:0] PAT_C = 20'h40100;

  initial begin
    rstN = 1'b0; irqIn = '0; hostEn = 1'b0; hostVal = 1'b1;
    step(1'b0, 1'b1, 1'b0, 1'b0, "R8 in reset");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R8 in reset");
    rstN  = 1'b1;
    irqIn = PAT_A;
    idle(6, "R8 continuous after reset");
    // continuous cycle, request changes right after capture
    runCycle(1'b0, 4, PAT_A, PAT_B, 3);
    idle(6, "R8 continuous no self-start");
    // short low run must not be taken as start
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R2 short low");
    step(1'b1, 1'b1, 1'b0, 1'b0, "R2 short low end");
    idle(4, "R2 ignored short run");
    // long start, stop of 2 selects quiet
    runCycle(1'b0, 8, PAT_B, PAT_B, 2);
    idle(5, "R9 quiet no change");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R9 change seen");
    irqIn = PAT_C;
    runCycle(1'b1, 3, PAT_C, PAT_C, 2);
    step(1'b0, 1'b1, 1'b0, 1'b0, "R9 clear seen");
    irqIn = '0;
    runCycle(1'b1, 3, '0, '0, 3);  // stop of 3 back to continuous
    step(1'b0, 1'b1, 1'b0, 1'b0, "R7 continuous again");
    irqIn = PAT_A;
    idle(6, "R7 R8 no self-start after long stop");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule